// File: doc/BRIEF.md
# Receive Character Queue with Interrupt Modes and Error Lock

This block sits between a character-level serial receiver and a host bus. Each character arrives with four status flags. It is stored in a shallow queue, and every entry keeps its own flags. The host, or a DMA engine acting through the same read strobe, removes characters from the head. A single receive interrupt-pending output is driven under one of four selectable policies: off, first character only, every character, or special conditions only. A two-bit vector code tells a character-available interrupt apart from a special-condition interrupt.

A character is special if any of these holds:

- it carries an overrun;
- it carries a framing error;
- it carries an end-of-frame mark;
- it carries a parity error and parity errors have been promoted by an enable input.

In the first-character and special-only policies, reading a special character freezes the queue. No further character becomes readable and the DMA request falls until an error-reset pulse arrives. Meanwhile the frozen character and its flags stay on the read outputs so software can inspect them. A re-arm pulse restores the first-character interrupt, which software uses after an end-of-frame. An elaboration option makes an overrun-only character block DMA without freezing the queue.

Top module: `rx_irq_lock_ctrl`

## Requirements
- R1: After reset, int_pend, dma_req and rx_avail are 0, vec_code is 2'b00, and rd_data and rd_stat are zero.
- R2: The queue holds up to DEPTH (default 3) characters in arrival order. Status is {eof, framing, overrun, parity} at bits 3..0. rx_avail is 1 when the queue is non-empty and unfrozen. In that case rd_data/rd_stat show the head entry and a read strobe removes it. Otherwise they show the most recently removed entry.
- R3: A character arriving while the queue is full, with no removal in that cycle, replaces the newest entry, and that entry's overrun bit (bit 1) is set.
- R4: A removed character is special if its overrun, framing or eof bit is set. A set parity bit makes it special only while par_special_en is 1.
- R5: mode_sel 2'b01 selects first-character mode. While armed and a character is available, int_pend is 1 with vec_code 2'b01 and dma_req is 0. Removing a character in this mode disarms. Reset arms.
- R6: In modes 2'b01 and 2'b11, removing a special character raises int_pend with vec_code 2'b11 from the next cycle. From that same cycle rx_avail and dma_req are 0, even if new characters arrive. rd_data/rd_stat keep showing the removed special character.
- R7: An err_reset pulse clears the freeze and the special pending state. Queued characters become readable again.
- R8: After the first character has been taken, later characters raise no first-character interrupt until a rearm pulse. After rearm, the next available character raises int_pend with vec_code 2'b01.
- R9: mode_sel 2'b10 selects all-characters mode. int_pend equals "queue non-empty", including characters already queued when the mode is entered. vec_code is 2'b11 when the head is special and 2'b01 otherwise. Special characters cause no freeze.
- R10: mode_sel 2'b11 selects special-only mode. Ordinary characters never raise int_pend.
- R11: dma_req is 1 exactly when all of these hold: the queue is non-empty, it is unfrozen, and the mode is either 2'b11 or 2'b01 after disarm.
- R12: mode_sel 2'b00 raises neither int_pend nor dma_req, while reads still remove characters.
- R13: With FSB_EN=1, removing a special character whose only cause is overrun raises the special interrupt and holds dma_req at 0 until err_reset. The queue stays readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | Receiver presents one character this cycle |
| rx_data | input | DATA_W | Received character |
| rx_par_err | input | 1 | Parity error flag of the character |
| rx_frm_err | input | 1 | Framing error flag of the character |
| rx_eof | input | 1 | End-of-frame flag of the character |
| mode_sel | input | 2 | Interrupt policy: 00 off, 01 first, 10 all, 11 special only |
| par_special_en | input | 1 | Promote parity errors to special conditions |
| rd_strobe | input | 1 | Remove the head character (host or DMA read) |
| err_reset | input | 1 | Clear freeze and special pending state |
| rearm | input | 1 | Re-arm the first-character interrupt |
| rd_data | output | DATA_W | Head character, or last removed one |
| rd_stat | output | 4 | Status of the character on rd_data |
| rx_avail | output | 1 | A character can be removed |
| int_pend | output | 1 | Receive interrupt pending |
| vec_code | output | 2 | 00 none, 01 character available, 11 special condition |
| dma_req | output | 1 | DMA transfer request |

## Verification
A wrong freeze flag shows up at the ports one cycle after the offending read. A missing freeze leaves rx_avail and dma_req high beside a 2'b11 vector. A freeze that does not clear keeps rx_avail low after err_reset. A corrupted queue pointer or count surfaces at the next read as a character out of order, a lost overrun bit, or a wrong empty indication on rx_avail. A stale arming bit shows as int_pend/vec_code 2'b01 with dma_req low when the bench expects DMA, or the reverse, on the first available character after a read or a rearm.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    RXM_OFF   = 2'b00,
    RXM_FIRST = 2'b01,
    RXM_ALL   = 2'b10,
    RXM_SPEC  = 2'b11
  } rx_mode_e;

  localparam int ST_W   = 4;
  localparam int ST_PAR = 0;
  localparam int ST_OVR = 1;
  localparam int ST_FRM = 2;
  localparam int ST_EOF = 3;

  localparam logic [1:0] VEC_NONE = 2'b00;
  localparam logic [1:0] VEC_CHAR = 2'b01;
  localparam logic [1:0] VEC_SPEC = 2'b11;

  function automatic logic is_special(input logic [ST_W-1:0] st, input logic par_en);
    return st[ST_OVR] | st[ST_FRM] | st[ST_EOF] | (par_en & st[ST_PAR]);
  endfunction

endpackage

// File: rtl/rxq_rst_sync.sv
module rxq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic [ST_W-1:0]   push_stat,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [ST_W-1:0]   head_stat,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] dat_q [DEPTH];
  logic [DATA_W-1:0] dat_d [DEPTH];
  logic [ST_W-1:0]   sts_q [DEPTH];
  logic [ST_W-1:0]   sts_d [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d, newest;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              do_pop, overwrite, wr_adv;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign do_pop    = pop & ~empty;
  assign overwrite = push & full & ~do_pop;
  assign wr_adv    = push & ~overwrite;
  assign newest    = (wr_q == '0) ? LAST : wr_q - 1'b1;
  assign head_data = dat_q[rd_q];
  assign head_stat = sts_q[rd_q];

  always_comb begin
    dat_d = dat_q;
    sts_d = sts_q;
    wr_d  = wr_q;
    rd_d  = rd_q;
    if (overwrite) begin
      dat_d[newest] = push_data;
      sts_d[newest] = push_stat | ST_W'(1 << ST_OVR);
    end else if (wr_adv) begin
      dat_d[wr_q] = push_data;
      sts_d[wr_q] = push_stat;
      wr_d        = ptr_inc(wr_q);
    end
    if (do_pop) rd_d = ptr_inc(rd_q);
    cnt_d = cnt_q + CNT_W'(wr_adv) - CNT_W'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dat_q[i] <= '0;
          sts_q[i] <= '0;
        end else if (push) begin
          dat_q[i] <= dat_d[i];
          sts_q[i] <= sts_d[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rxq_irq_ctrl.sv
module rxq_irq_ctrl
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit FSB_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rx_mode_e          mode,
  input  logic              par_en,
  input  logic              rd_strobe,
  input  logic              err_reset,
  input  logic              rearm,
  input  logic              empty,
  input  logic [DATA_W-1:0] head_data,
  input  logic [ST_W-1:0]   head_stat,
  output logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [ST_W-1:0]   rd_stat,
  output logic              rx_avail,
  output logic              int_pend,
  output logic [1:0]        vec_code,
  output logic              dma_req,
  output logic              lock_o,
  output logic              spec_o
);
  logic              lock_q, lock_d, spec_q, spec_d, blk_q, blk_d, armed_q, armed_d;
  logic [DATA_W-1:0] held_d_q, held_d_d;
  logic [ST_W-1:0]   held_s_q, held_s_d;
  logic              lock_mode, pop_sp, lock_set, blk_set, all_hit, first_hit;

  assign rx_avail  = ~empty & ~lock_q;
  assign pop       = rd_strobe & rx_avail;
  assign lock_mode = (mode == RXM_FIRST) | (mode == RXM_SPEC);
  assign pop_sp    = pop & lock_mode & is_special(head_stat, par_en);

  generate
    if (FSB_EN) begin : g_fsb
      logic [ST_W-1:0] no_ovr;
      assign no_ovr   = head_stat & ~ST_W'(1 << ST_OVR);
      assign lock_set = pop_sp & is_special(no_ovr, par_en);
      assign blk_set  = pop_sp & head_stat[ST_OVR];
    end else begin : g_plain
      assign lock_set = pop_sp;
      assign blk_set  = 1'b0;
    end
  endgenerate

  always_comb begin
    lock_d   = lock_set | (lock_q & ~err_reset);
    spec_d   = pop_sp   | (spec_q & ~err_reset);
    blk_d    = blk_set  | (blk_q  & ~err_reset);
    armed_d  = rearm | (armed_q & ~(pop & (mode == RXM_FIRST)));
    held_d_d = pop ? head_data : held_d_q;
    held_s_d = pop ? head_stat : held_s_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      spec_q   <= 1'b0;
      blk_q    <= 1'b0;
      armed_q  <= 1'b1;
      held_d_q <= '0;
      held_s_q <= '0;
    end else begin
      lock_q   <= lock_d;
      spec_q   <= spec_d;
      blk_q    <= blk_d;
      armed_q  <= armed_d;
      held_d_q <= held_d_d;
      held_s_q <= held_s_d;
    end
  end

  assign all_hit   = (mode == RXM_ALL) & ~empty;
  assign first_hit = (mode == RXM_FIRST) & armed_q & rx_avail;

  always_comb begin
    rd_data  = rx_avail ? head_data : held_d_q;
    rd_stat  = rx_avail ? head_stat : held_s_q;
    int_pend = spec_q | all_hit | first_hit;
    if (spec_q)         vec_code = VEC_SPEC;
    else if (all_hit)   vec_code = is_special(head_stat, par_en) ? VEC_SPEC : VEC_CHAR;
    else if (first_hit) vec_code = VEC_CHAR;
    else                vec_code = VEC_NONE;
    dma_req = ~empty & ~lock_q & ~blk_q &
              ((mode == RXM_SPEC) | ((mode == RXM_FIRST) & ~armed_q));
  end

  assign lock_o = lock_q;
  assign spec_o = spec_q;
endmodule

// File: rtl/rx_irq_lock_ctrl.sv
module rx_irq_lock_ctrl
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3,
  parameter bit FSB_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  input  logic              rx_eof,
  input  logic [1:0]        mode_sel,
  input  logic              par_special_en,
  input  logic              rd_strobe,
  input  logic              err_reset,
  input  logic              rearm,
  output logic [DATA_W-1:0] rd_data,
  output logic [3:0]        rd_stat,
  output logic              rx_avail,
  output logic              int_pend,
  output logic [1:0]        vec_code,
  output logic              dma_req
);
  logic              srst_n, pop, fifo_empty, fifo_full, lock_w, spec_w;
  logic [DATA_W-1:0] head_data;
  logic [ST_W-1:0]   head_stat, stat_in;

  assign stat_in = {rx_eof, rx_frm_err, 1'b0, rx_par_err};

  rxq_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  rxq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(srst_n), .push(rx_valid), .push_data(rx_data),
    .push_stat(stat_in), .pop(pop), .head_data(head_data),
    .head_stat(head_stat), .empty(fifo_empty), .full(fifo_full)
  );

  rxq_irq_ctrl #(.DATA_W(DATA_W), .FSB_EN(FSB_EN)) u_ctl (
    .clk(clk), .rst_n(srst_n), .mode(rx_mode_e'(mode_sel)),
    .par_en(par_special_en), .rd_strobe(rd_strobe), .err_reset(err_reset),
    .rearm(rearm), .empty(fifo_empty), .head_data(head_data),
    .head_stat(head_stat), .pop(pop), .rd_data(rd_data), .rd_stat(rd_stat),
    .rx_avail(rx_avail), .int_pend(int_pend), .vec_code(vec_code),
    .dma_req(dma_req), .lock_o(lock_w), .spec_o(spec_w)
  );
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk
  import rxq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       par_special_en,
  input logic       rd_strobe,
  input logic       err_reset,
  input logic       rx_avail,
  input logic [3:0] rd_stat,
  input logic       int_pend,
  input logic [1:0] vec_code,
  input logic       dma_req,
  input logic       lock_w,
  input logic       spec_w,
  input logic       fifo_empty,
  input logic       fifo_full
);
  assert_lock_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_w |-> (!rx_avail && !dma_req));

  assert_special_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && rx_avail && mode_sel == 2'b11 && !err_reset &&
     is_special(rd_stat, par_special_en))
    |=> (int_pend && vec_code == VEC_SPEC && !dma_req));

  assert_err_reset_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_reset && !rd_strobe) |=> !lock_w);

  assert_all_mode_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10 && !spec_w) |-> (int_pend == !fifo_empty));

  assert_vec_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_code != 2'b10) && (int_pend == (vec_code != VEC_NONE)));

  assert_spec_mode_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11 && !spec_w) |-> !int_pend);

  assert_off_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b00 && !spec_w) |-> (!int_pend && !dma_req));

  assert_no_empty_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_empty && fifo_full));
endmodule

bind rx_irq_lock_ctrl rxq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .par_special_en(par_special_en),
  .rd_strobe(rd_strobe), .err_reset(err_reset), .rx_avail(rx_avail),
  .rd_stat(rd_stat), .int_pend(int_pend), .vec_code(vec_code),
  .dma_req(dma_req), .lock_w(lock_w), .spec_w(spec_w),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full)
);

// File: tb/sim_rx_irq_lock_ctrl.sv
`timescale 1ns/1ps
module sim_rx_irq_lock_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid, rx_par_err, rx_frm_err, rx_eof;
  logic [7:0] rx_data;
  logic [1:0] mode_sel;
  logic       par_special_en, rd_strobe, err_reset, rearm;
  logic [7:0] rd_data, rd_data1;
  logic [3:0] rd_stat, rd_stat1;
  logic       rx_avail, int_pend, dma_req, rx_avail1, int_pend1, dma_req1;
  logic [1:0] vec_code, vec_code1;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  rx_irq_lock_ctrl #(.DATA_W(8), .DEPTH(3), .FSB_EN(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_eof(rx_eof),
    .mode_sel(mode_sel), .par_special_en(par_special_en), .rd_strobe(rd_strobe),
    .err_reset(err_reset), .rearm(rearm), .rd_data(rd_data), .rd_stat(rd_stat),
    .rx_avail(rx_avail), .int_pend(int_pend), .vec_code(vec_code), .dma_req(dma_req));

  rx_irq_lock_ctrl #(.DATA_W(8), .DEPTH(3), .FSB_EN(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_eof(rx_eof),
    .mode_sel(mode_sel), .par_special_en(par_special_en), .rd_strobe(rd_strobe),
    .err_reset(err_reset), .rearm(rearm), .rd_data(rd_data1), .rd_stat(rd_stat1),
    .rx_avail(rx_avail1), .int_pend(int_pend1), .vec_code(vec_code1), .dma_req(dma_req1));

  // reference model of the requirements (default variant)
  logic [7:0] mq_d [3];
  logic [3:0] mq_s [3];
  int         mcnt;
  logic       m_lock, m_spec, m_armed, t_pop, t_full;
  logic [7:0] m_hd;
  logic [3:0] m_hs;

  function automatic logic bsp(input logic [3:0] s, input logic pe);
    return s[1] || s[2] || s[3] || (pe && s[0]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt = 0; m_lock = 0; m_spec = 0; m_armed = 1; m_hd = 0; m_hs = 0;
      for (int i = 0; i < 3; i++) begin mq_d[i] = 0; mq_s[i] = 0; end
    end else begin
      t_pop  = rd_strobe && mcnt > 0 && !m_lock;
      t_full = (mcnt == 3);
      if (err_reset) begin m_lock = 0; m_spec = 0; end
      if (t_pop) begin
        m_hd = mq_d[0]; m_hs = mq_s[0];
        if (bsp(mq_s[0], par_special_en) && (mode_sel == 2'b01 || mode_sel == 2'b11)) begin
          m_lock = 1; m_spec = 1;
        end
        if (mode_sel == 2'b01) m_armed = 0;
        mq_d[0] = mq_d[1]; mq_s[0] = mq_s[1];
        mq_d[1] = mq_d[2]; mq_s[1] = mq_s[2];
        mcnt--;
      end
      if (rearm) m_armed = 1;
      if (rx_valid) begin
        if (t_full && !t_pop) begin
          mq_d[2] = rx_data; mq_s[2] = {rx_eof, rx_frm_err, 1'b1, rx_par_err};
        end else begin
          mq_d[mcnt] = rx_data; mq_s[mcnt] = {rx_eof, rx_frm_err, 1'b0, rx_par_err};
          mcnt++;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_all();
    logic ea, eall, efirst, ep;
    logic [1:0] ev;
    ea     = mcnt > 0 && !m_lock;
    eall   = mode_sel == 2'b10 && mcnt > 0;
    efirst = mode_sel == 2'b01 && m_armed && ea;
    ep     = m_spec || eall || efirst;
    ev     = m_spec ? 2'b11 : eall ? (bsp(mq_s[0], par_special_en) ? 2'b11 : 2'b01)
           : efirst ? 2'b01 : 2'b00;
    chk("R2", "rx_avail", 32'(rx_avail), 32'(ea));
    chk("R2", "rd_data", 32'(rd_data), 32'(ea ? mq_d[0] : m_hd));
    chk("R2", "rd_stat", 32'(rd_stat), 32'(ea ? mq_s[0] : m_hs));
    chk("R9", "int_pend", 32'(int_pend), 32'(ep));
    chk("R9", "vec_code", 32'(vec_code), 32'(ev));
    chk("R11", "dma_req", 32'(dma_req),
        32'(mcnt > 0 && !m_lock && (mode_sel == 2'b11 || (mode_sel == 2'b01 && !m_armed))));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    rx_valid = 0; rd_strobe = 0; err_reset = 0; rearm = 0;
    rx_par_err = 0; rx_frm_err = 0; rx_eof = 0;
    cmp_all();
  endtask

  task automatic push(input logic [7:0] d, input logic p, input logic f, input logic e);
    rx_valid = 1; rx_data = d; rx_par_err = p; rx_frm_err = f; rx_eof = e;
    tick();
  endtask

  task automatic rd();     rd_strobe = 1; tick(); endtask
  task automatic errrst(); err_reset = 1; tick(); endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) tick();
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    rx_valid = 0; rx_data = 0; rx_par_err = 0; rx_frm_err = 0; rx_eof = 0;
    mode_sel = 0; par_special_en = 0; rd_strobe = 0; err_reset = 0; rearm = 0;
    void'($urandom(32'd20240611));
    do_reset();
    chk("R1", "int_pend", 32'(int_pend), 0);
    chk("R1", "vec_code", 32'(vec_code), 0);
    chk("R1", "dma_req", 32'(dma_req), 0);
    chk("R1", "rx_avail", 32'(rx_avail), 0);
    chk("R1", "rd_data", 32'(rd_data), 0);

    // special-only mode, overrun and freeze
    mode_sel = 2'b11;
    push(8'h11, 0, 0, 0); push(8'h22, 0, 0, 0); push(8'h33, 0, 0, 0);
    chk("R10", "int_pend ordinary", 32'(int_pend), 0);
    chk("R11", "dma_req", 32'(dma_req), 1);
    chk("R2", "head", 32'(rd_data), 32'h11);
    push(8'h44, 0, 0, 0);
    rd(); chk("R2", "order", 32'(rd_data), 32'h22);
    rd(); chk("R3", "overwritten data", 32'(rd_data), 32'h44);
    chk("R3", "overrun bit", 32'(rd_stat), 32'h2);
    rd();
    chk("R6", "int_pend", 32'(int_pend), 1);
    chk("R6", "vec_code", 32'(vec_code), 3);
    chk("R6", "dma_req", 32'(dma_req), 0);
    chk("R13", "u1 int_pend", 32'(int_pend1), 1);
    chk("R13", "u1 dma_req", 32'(dma_req1), 0);
    push(8'h55, 0, 0, 0);
    chk("R6", "rx_avail frozen", 32'(rx_avail), 0);
    chk("R6", "held data", 32'(rd_data), 32'h44);
    chk("R6", "held stat", 32'(rd_stat), 32'h2);
    chk("R13", "u1 readable", 32'(rx_avail1), 1);
    chk("R13", "u1 dma blocked", 32'(dma_req1), 0);
    errrst();
    chk("R7", "rx_avail", 32'(rx_avail), 1);
    chk("R7", "rd_data", 32'(rd_data), 32'h55);
    chk("R7", "int_pend", 32'(int_pend), 0);
    chk("R13", "u1 dma after reset", 32'(dma_req1), 1);
    rd();

    // parity promotion
    do_reset(); mode_sel = 2'b11; par_special_en = 0;
    push(8'h66, 1, 0, 0); rd(); push(8'h77, 0, 0, 0);
    chk("R4", "parity ignored no freeze", 32'(rx_avail), 1);
    chk("R4", "parity ignored no pend", 32'(int_pend), 0);
    rd(); par_special_en = 1;
    push(8'h88, 1, 0, 0); rd(); push(8'h99, 0, 0, 0);
    chk("R4", "parity promoted pend", 32'(int_pend), 1);
    chk("R4", "parity promoted freeze", 32'(rx_avail), 0);
    errrst(); rd(); par_special_en = 0;

    // first-character mode
    do_reset(); mode_sel = 2'b01;
    push(8'hA1, 0, 0, 0);
    chk("R5", "int_pend", 32'(int_pend), 1);
    chk("R5", "vec_code", 32'(vec_code), 1);
    chk("R5", "dma_req", 32'(dma_req), 0);
    rd(); chk("R5", "pend after read", 32'(int_pend), 0);
    push(8'hA2, 0, 0, 0);
    chk("R11", "dma after first", 32'(dma_req), 1);
    push(8'hA3, 0, 0, 1); rd(); rd();
    chk("R6", "eof vec", 32'(vec_code), 3);
    chk("R6", "eof frozen", 32'(rx_avail), 0);
    errrst();
    push(8'hA4, 0, 0, 0);
    chk("R8", "no first int before rearm", 32'(int_pend), 0);
    rd(); rearm = 1; tick();
    push(8'hA5, 0, 0, 0);
    chk("R8", "first int after rearm", 32'(int_pend), 1);
    chk("R8", "vec after rearm", 32'(vec_code), 1);

    // off mode, then all-characters mode
    do_reset(); mode_sel = 2'b00;
    push(8'hB1, 0, 0, 0); push(8'hB2, 0, 1, 0); push(8'hB0, 0, 0, 0);
    chk("R12", "no pend", 32'(int_pend), 0);
    chk("R12", "no dma", 32'(dma_req), 0);
    rd(); chk("R12", "read works", 32'(rd_data), 32'hB2);
    mode_sel = 2'b10; tick();
    chk("R9", "pend for queued", 32'(int_pend), 1);
    chk("R9", "vec special head", 32'(vec_code), 3);
    rd(); chk("R9", "no freeze", 32'(rx_avail), 1);
    chk("R9", "vec ordinary head", 32'(vec_code), 1);
    rd(); chk("R9", "pend clears", 32'(int_pend), 0);

    // constrained random against the model
    for (int c = 0; c < 4000; c++) begin
      if (($urandom % 100) < 2) mode_sel = 2'($urandom);
      if (($urandom % 100) < 2) par_special_en = 1'($urandom);
      rx_valid   = ($urandom % 100) < 40;
      rx_data    = 8'($urandom);
      rx_par_err = ($urandom % 100) < 15;
      rx_frm_err = ($urandom % 100) < 8;
      rx_eof     = ($urandom % 100) < 8;
      rd_strobe  = ($urandom % 100) < 40;
      err_reset  = ($urandom % 100) < 6;
      rearm      = ($urandom % 100) < 4;
      tick();
    end
    report();
  end
endmodule